// File: doc/BRIEF.md
# Snooping Write-Back Invalidate Cache Controller

This block is a small direct-mapped, write-back cache controller for one processor in a shared-memory system where all caches share one broadcast bus. Every line holds a single data word and one of three coherence states: Invalid, Shared (clean and read-only) or Exclusive (the only copy, writable and dirty). The controller serves processor reads and writes. When it needs the bus it raises a request, waits for a grant, and then places a read-miss, write-miss or write-back transaction on the bus. It also watches every transaction that other caches place on the bus and updates the matching line.

A processor request is held until the controller pulses `cpu_ready`. Read misses finish when reply data arrives on the fill inputs. Write misses finish in the grant cycle, because a line holds one word and the write overwrites it. Suppose another cache misses on a line that this cache holds dirty. The controller then drives the line's data on its snoop-response port and raises an abort, so that memory does not answer. Snooped transactions that carry this cache's own requester ID are ignored.

Top module: `scc_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. `cpu_ready`, `bus_req` and `snp_abort` are low.
- R2: A read to an Invalid or non-matching line raises `bus_req`. In the grant cycle it drives `bus_valid` with `bus_cmd` = 1 (read miss) and the request address. The cycle after `fill_valid`, it pulses `cpu_ready` with `cpu_rdata` equal to the fill data, and the line becomes Shared.
- R3: A write to an Invalid line drives `bus_cmd` = 2 (write miss) with the write data in the grant cycle. It pulses `cpu_ready` in the next cycle, and the line becomes Exclusive and holds the written word.
- R4: A write to a Shared line with a matching tag is handled as a miss: a write miss (`bus_cmd` = 2) is issued, and the line becomes Exclusive.
- R5: A read to a Shared or Exclusive line, or a write to an Exclusive line, with a matching tag causes no bus request. `cpu_ready` pulses for exactly one cycle, one cycle after the request is seen.
- R6: A miss whose line is Exclusive under a different tag first issues a write-back (`bus_cmd` = 3). The write-back carries address {old tag, index} (the index is the low address bits) and the old data. Only after that does the controller issue the read or write miss for the new address.
- R7: A read miss that replaces a Shared line issues the read miss as its first bus transaction, with no write-back.
- R8: A snooped write miss (`snp_cmd` = 2) from another requester to a line held Shared makes that line Invalid. A snoop whose tag does not match the resident line changes nothing.
- R9: A snooped read miss (`snp_cmd` = 1) from another requester to a line held Exclusive raises `snp_abort` for one cycle, on the cycle after the snoop, with `snp_data` equal to the line's data. The line becomes Shared.
- R10: A snooped write miss from another requester to a line held Exclusive raises `snp_abort` with the line's data, and the line becomes Invalid.
- R11: Snooped transactions whose `snp_id` equals the cache's own ID have no effect on line state or on `snp_abort`.
- R12: `cpu_ready` stays low while a bus request waits for a grant. When a snoop and a processor request target the same index in the same cycle, the snoop is applied first, and the processor request is evaluated one cycle later against the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address, low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Transaction driven this cycle |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_data | output | DATA_W | Write-miss or write-back data |
| bus_src | output | ID_W | Requester ID of this cache |
| fill_valid | input | 1 | Reply data for a pending read miss |
| fill_data | input | DATA_W | Reply word |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_abort | output | 1 | Dirty data supplied; memory must not answer |
| snp_data | output | DATA_W | Dirty line data supplied with the abort |

## Verification
The assertions check, on every cycle, the behaviours that show at the ports: the ready pulse lasts one cycle and never overlaps a bus request, a write-back is always followed by a further miss request, and a write miss completes on the next cycle. They also check that an abort only follows a miss snooped from another requester, never one from this cache's own ID. Line states cannot be seen directly, so the bench's reference model tracks every line. After each snoop it probes the line through later processor accesses, and each such access must show the hit, miss or write-back that the model predicts. The bench also covers the ordering cases: a replaced dirty line is written back before the new miss, and a snoop that collides with a processor request on the same index is applied first.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_EVICT,
        CS_ISSUE,
        CS_FILL,
        CS_DONE
    } ctl_st_e;
endpackage

// File: rtl/scc_line_array.sv
`timescale 1ns/1ps
module scc_line_array
    import scc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    output logic [TAG_W-1:0]  cpu_tag,
    output line_st_e          cpu_st,
    output logic [DATA_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic [TAG_W-1:0]  snp_tag,
    output line_st_e          snp_st,
    output logic [DATA_W-1:0] snp_data,
    input  logic              cw_en,
    input  logic [TAG_W-1:0]  cw_tag,
    input  line_st_e          cw_st,
    input  logic              cw_data_en,
    input  logic [DATA_W-1:0] cw_data,
    input  logic              sw_en,
    input  line_st_e          sw_st
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        line_st_e          st;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t rd_arr [LINES];

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        line_t ln_d, ln_q;
        logic  cpu_sel, snp_sel;

        assign cpu_sel = (cpu_idx == IDX_W'(gi));
        assign snp_sel = (snp_idx == IDX_W'(gi));

        always_comb begin
            ln_d = ln_q;
            if (sw_en && snp_sel) begin
                ln_d.st = sw_st;
            end
            if (cw_en && cpu_sel) begin
                ln_d.tag = cw_tag;
                ln_d.st  = cw_st;
            end
            if (cw_data_en && cpu_sel) begin
                ln_d.data = cw_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ln_q <= '{tag: '0, st: LS_INV, data: '0};
            end else begin
                ln_q <= ln_d;
            end
        end

        assign rd_arr[gi] = ln_q;
    end

    assign cpu_tag  = rd_arr[cpu_idx].tag;
    assign cpu_st   = rd_arr[cpu_idx].st;
    assign cpu_data = rd_arr[cpu_idx].data;
    assign snp_tag  = rd_arr[snp_idx].tag;
    assign snp_st   = rd_arr[snp_idx].st;
    assign snp_data = rd_arr[snp_idx].data;
endmodule

// File: rtl/scc_snoop.sv
`timescale 1ns/1ps
module scc_snoop
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  line_st_e          ln_st,
    input  logic [DATA_W-1:0] ln_data,
    output logic              relevant,
    output logic              sw_en,
    output line_st_e          sw_st,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

    typedef struct packed {
        logic              abort;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic tag_hit;

    assign relevant = snp_valid && (snp_id != OWN_ID) &&
                      (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS);
    assign tag_hit  = relevant && (ln_st != LS_INV) &&
                      (ln_tag == snp_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.abort = 1'b0;
        sw_en       = 1'b0;
        sw_st       = LS_INV;
        if (tag_hit) begin
            if (ln_st == LS_EXC) begin
                rsp_d.abort = 1'b1;
                rsp_d.data  = ln_data;
                sw_en       = 1'b1;
                sw_st       = (snp_cmd == BC_RDMISS) ? LS_SHD : LS_INV;
            end else if (snp_cmd == BC_WRMISS) begin
                sw_en = 1'b1;
                sw_st = LS_INV;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign snp_abort = rsp_q.abort;
    assign snp_data  = rsp_q.data;
endmodule

// File: rtl/scc_cpu_ctrl.sv
`timescale 1ns/1ps
module scc_cpu_ctrl
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              snp_stall,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_valid,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  line_st_e          ln_st,
    input  logic [DATA_W-1:0] ln_data,
    output logic              cw_en,
    output logic [ADDR_W-IDX_W-1:0] cw_tag,
    output line_st_e          cw_st,
    output logic              cw_data_en,
    output logic [DATA_W-1:0] cw_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           st;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t q, d;
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             tag_hit, dirty_victim;

    assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx      = cpu_addr[IDX_W-1:0];
    assign tag_hit      = (ln_st != LS_INV) && (ln_tag == req_tag);
    assign dirty_victim = (ln_st == LS_EXC) && (ln_tag != req_tag);

    always_comb begin
        d          = q;
        d.ready    = 1'b0;
        bus_req    = 1'b0;
        bus_valid  = 1'b0;
        bus_cmd    = BC_NONE;
        bus_addr   = '0;
        bus_data   = '0;
        cw_en      = 1'b0;
        cw_tag     = req_tag;
        cw_st      = LS_INV;
        cw_data_en = 1'b0;
        cw_data    = cpu_wdata;
        case (q.st)
            CS_IDLE: begin
                if (cpu_req && !snp_stall) begin
                    if (tag_hit && (!cpu_we || ln_st == LS_EXC)) begin
                        d.st    = CS_DONE;
                        d.ready = 1'b1;
                        if (cpu_we) begin
                            cw_data_en = 1'b1;
                        end else begin
                            d.rdata = ln_data;
                        end
                    end else if (dirty_victim) begin
                        d.st = CS_EVICT;
                    end else begin
                        d.st = CS_ISSUE;
                    end
                end
            end
            CS_EVICT: begin
                bus_req = 1'b1;
                if (!dirty_victim) begin
                    d.st = CS_ISSUE;
                end else if (bus_gnt) begin
                    bus_valid = 1'b1;
                    bus_cmd   = BC_WRBACK;
                    bus_addr  = {ln_tag, req_idx};
                    bus_data  = ln_data;
                    cw_en     = 1'b1;
                    cw_tag    = ln_tag;
                    cw_st     = LS_INV;
                    d.st      = CS_ISSUE;
                end
            end
            CS_ISSUE: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_valid = 1'b1;
                    bus_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
                    bus_addr  = cpu_addr;
                    bus_data  = cpu_wdata;
                    cw_en     = 1'b1;
                    cw_st     = cpu_we ? LS_EXC : LS_SHD;
                    if (cpu_we) begin
                        cw_data_en = 1'b1;
                        d.ready    = 1'b1;
                        d.st       = CS_DONE;
                    end else begin
                        d.st = CS_FILL;
                    end
                end
            end
            CS_FILL: begin
                if (fill_valid) begin
                    cw_data_en = 1'b1;
                    cw_data    = fill_data;
                    d.rdata    = fill_data;
                    d.ready    = 1'b1;
                    d.st       = CS_DONE;
                end
            end
            CS_DONE: begin
                d.st = CS_IDLE;
            end
            default: begin
                d.st = CS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CS_IDLE, ready: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign cpu_ready = q.ready;
    assign cpu_rdata = q.rdata;
endmodule

// File: rtl/scc_cache.sv
`timescale 1ns/1ps
module scc_cache
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic [ID_W-1:0]   bus_src,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0]  c_tag, s_tag, cw_tag;
    line_st_e          c_st, s_st, cw_st, sw_st;
    logic [DATA_W-1:0] c_data, s_data, cw_data;
    logic              cw_en, cw_data_en, sw_en, snp_rel, snp_stall;
    bus_cmd_e          cmd_e;

    assign snp_stall = snp_rel && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
    assign bus_cmd   = cmd_e;
    assign bus_src   = ID_W'(MY_ID);

    scc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .cpu_idx(cpu_addr[IDX_W-1:0]), .cpu_tag(c_tag), .cpu_st(c_st), .cpu_data(c_data),
        .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(s_tag), .snp_st(s_st), .snp_data(s_data),
        .cw_en(cw_en), .cw_tag(cw_tag), .cw_st(cw_st),
        .cw_data_en(cw_data_en), .cw_data(cw_data),
        .sw_en(sw_en), .sw_st(sw_st)
    );

    scc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
                .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)),
        .snp_addr(snp_addr), .snp_id(snp_id),
        .ln_tag(s_tag), .ln_st(s_st), .ln_data(s_data),
        .relevant(snp_rel), .sw_en(sw_en), .sw_st(sw_st),
        .snp_abort(snp_abort), .snp_data(snp_data)
    );

    scc_cpu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .snp_stall(snp_stall), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .bus_valid(bus_valid), .bus_cmd(cmd_e), .bus_addr(bus_addr),
        .bus_data(bus_data), .fill_valid(fill_valid), .fill_data(fill_data),
        .ln_tag(c_tag), .ln_st(c_st), .ln_data(c_data),
        .cw_en(cw_en), .cw_tag(cw_tag), .cw_st(cw_st),
        .cw_data_en(cw_data_en), .cw_data(cw_data)
    );
endmodule

// File: rtl/scc_cache_chk.sv
`timescale 1ns/1ps
module scc_cache_chk #(
    parameter int ID_W  = 2,
    parameter int MY_ID = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ready,
    input logic            bus_req,
    input logic            bus_valid,
    input logic [1:0]      bus_cmd,
    input logic            snp_valid,
    input logic [1:0]      snp_cmd,
    input logic [ID_W-1:0] snp_id,
    input logic            snp_abort
);
    localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R5
    AST_READY_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req); // R12
    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd3) |=> bus_req); // R6
    AST_WM_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd2) |=> cpu_ready); // R3
    AST_CMD_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_cmd != 2'd0)); // R2
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && snp_abort) |-> $past(snp_valid && snp_id != OWN_ID &&
                                        (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R9
    AST_OWN_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(snp_valid && snp_id == OWN_ID)) |-> !snp_abort); // R11
endmodule

bind scc_cache scc_cache_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_id(snp_id), .snp_abort(snp_abort)
);

// File: tb/scc_cache_tb_top.sv
`timescale 1ns/1ps
module scc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, bus_req, bus_gnt = 1'b0, bus_valid;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_data;
    logic [1:0]  bus_src;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_data = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic [1:0]  snp_id = '0;
    logic        snp_abort;
    logic [15:0] snp_data;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;
    int mst [4];
    int mtag [4];
    int mdat [4];

    always #5 clk = ~clk;

    scc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_src(bus_src), .fill_valid(fill_valid),
        .fill_data(fill_data), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_id(snp_id), .snp_abort(snp_abort),
        .snp_data(snp_data)
    );

    task automatic chk(input bit ok, input string r, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // one clock; compare the per-cycle outputs against the model's expectation
    task automatic tick(input bit er, input bit ey, input bit ea, input string r);
        @(posedge clk);
        @(negedge clk);
        chk(bus_req == er, r, "bus_req", int'(bus_req), int'(er));
        chk(cpu_ready == ey, r, "cpu_ready", int'(cpu_ready), int'(ey));
        chk(snp_abort == ea, r, "snp_abort", int'(snp_abort), int'(ea));
    endtask

    task automatic grant(input int cmd, input int a, input int d, input bit cd,
                         input int dly, input bit pr, input bit py, input string r);
        repeat (dly) tick(1'b1, 1'b0, 1'b0, r);
        bus_gnt = 1'b1;
        #1;
        chk(bus_valid == 1'b1, r, "bus_valid", int'(bus_valid), 1);
        chk(int'(bus_cmd) == cmd, r, "bus_cmd", int'(bus_cmd), cmd);
        chk(int'(bus_addr) == a, r, "bus_addr", int'(bus_addr), a);
        if (cd) chk(int'(bus_data) == d, r, "bus_data", int'(bus_data), d);
        chk(int'(bus_src) == 1, r, "bus_src", int'(bus_src), 1);
        tick(pr, py, 1'b0, r);
        bus_gnt = 1'b0;
    endtask

    // processor access; d is write data or, for a read miss, the fill word
    task automatic cpu_op(input bit we, input int a, input int d, input int dly,
                          input string r);
        int  idx = a % 4;
        int  tg  = a / 4;
        bit  hit = (mst[idx] != 0) && (mtag[idx] == tg) && (!we || mst[idx] == 2);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 8'(a); cpu_wdata = 16'(d);
        if (hit) begin
            tick(1'b0, 1'b1, 1'b0, r);
            if (!we) chk(int'(cpu_rdata) == mdat[idx], r, "hit rdata", int'(cpu_rdata), mdat[idx]);
            else mdat[idx] = d;
        end else begin
            tick(1'b1, 1'b0, 1'b0, r);
            if (mst[idx] == 2 && mtag[idx] != tg) begin
                grant(3, mtag[idx] * 4 + idx, mdat[idx], 1'b1, dly, 1'b1, 1'b0, r);
                mst[idx] = 0;
            end
            grant(we ? 2 : 1, a, d, we, dly, 1'b0, we, r);
            mtag[idx] = tg;
            if (we) begin
                mst[idx] = 2; mdat[idx] = d;
            end else begin
                fill_valid = 1'b1; fill_data = 16'(d);
                tick(1'b0, 1'b1, 1'b0, r);
                fill_valid = 1'b0;
                chk(int'(cpu_rdata) == d, r, "fill rdata", int'(cpu_rdata), d);
                mst[idx] = 1; mdat[idx] = d;
            end
        end
        cpu_req = 1'b0;
        tick(1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic snoop(input int cmd, input int a, input int id, input string r);
        int idx = a % 4;
        bit match = (id != 1) && (cmd == 1 || cmd == 2) &&
                    (mst[idx] != 0) && (mtag[idx] == a / 4);
        bit ab = match && (mst[idx] == 2);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = 8'(a); snp_id = 2'(id);
        tick(1'b0, 1'b0, ab, r);
        snp_valid = 1'b0;
        if (ab) chk(int'(snp_data) == mdat[idx], r, "snp_data", int'(snp_data), mdat[idx]);
        if (match) begin
            if (mst[idx] == 2) mst[idx] = (cmd == 1) ? 1 : 0;
            else if (cmd == 2) mst[idx] = 0;
        end
        tick(1'b0, 1'b0, 1'b0, r);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = 0; mdat[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(cpu_ready == 1'b0, "R1", "cpu_ready", int'(cpu_ready), 0);
        chk(bus_req == 1'b0, "R1", "bus_req", int'(bus_req), 0);
        chk(snp_abort == 1'b0, "R1", "snp_abort", int'(snp_abort), 0);
        tick(1'b0, 1'b0, 1'b0, "R1");

        cpu_op(1'b0, 'h14, 'hA1A1, 2, "R2");   // read miss after reset, late grant (R12)
        cpu_op(1'b0, 'h14, 0, 0, "R5");        // read hit on Shared
        cpu_op(1'b1, 'h14, 'hBEEF, 1, "R4");   // write to Shared upgrades
        cpu_op(1'b1, 'h14, 'h1234, 0, "R5");   // write hit on Exclusive
        cpu_op(1'b0, 'h14, 0, 0, "R5");
        cpu_op(1'b1, 'h21, 'h2121, 0, "R3");   // write miss on Invalid
        cpu_op(1'b0, 'h21, 0, 0, "R3");
        cpu_op(1'b0, 'h25, 'h2525, 1, "R6");   // replace dirty line
        cpu_op(1'b0, 'h29, 'h2929, 0, "R7");   // replace clean line
        snoop(2, 'h29, 2, "R8");
        cpu_op(1'b0, 'h29, 'h0929, 0, "R8");   // must miss again
        snoop(2, 'h19, 2, "R8");               // tag mismatch: no effect
        cpu_op(1'b0, 'h29, 0, 0, "R8");
        cpu_op(1'b1, 'h32, 'h3232, 0, "R3");
        snoop(1, 'h32, 2, "R9");
        cpu_op(1'b0, 'h32, 0, 0, "R9");        // Shared: hit
        cpu_op(1'b1, 'h32, 'h4444, 0, "R9");   // Shared: write miss
        snoop(2, 'h32, 3, "R10");
        cpu_op(1'b0, 'h32, 'h5555, 0, "R10");  // Invalid: miss
        cpu_op(1'b1, 'h33, 'h3333, 0, "R3");
        snoop(2, 'h33, 1, "R11");              // own ID: ignored
        snoop(1, 'h33, 1, "R11");
        cpu_op(1'b0, 'h33, 0, 0, "R11");       // still Exclusive, hit
        cpu_op(1'b1, 'h33, 'h6666, 0, "R11");  // write hit, no bus
        cpu_op(1'b1, 'h17, 'h7777, 2, "R6");   // write miss replacing dirty

        // R12: snoop and processor read on the same index in the same cycle
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h14;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h14; snp_id = 2'd2;
        tick(1'b0, 1'b0, 1'b1, "R12");
        snp_valid = 1'b0;
        chk(int'(snp_data) == mdat[0], "R12", "snp_data", int'(snp_data), mdat[0]);
        mst[0] = 1;
        tick(1'b0, 1'b1, 1'b0, "R12");
        chk(int'(cpu_rdata) == mdat[0], "R12", "rdata", int'(cpu_rdata), mdat[0]);
        cpu_req = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R12");
        cpu_op(1'b1, 'h14, 'h8888, 0, "R12");  // line now Shared: write miss

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule